// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block scans a switch matrix of five column drive lines and six row sense lines, which covers up to thirty keys. While scanning is enabled, it pulls one column low at a time and reads the six active-low rows. A low row on the driven column means the switch at that crossing is closed. The order in which columns are visited comes from a programmable table of five slots. Each slot names a column index, and an index of 5, 6 or 7 marks the slot as skipped. Scan timing and debounce timing both advance on a slow tick enable, nominally 1 kHz, which comes from outside the block.

When a row pattern appears on the driven column, the sequencer stops on that column. The pattern must then stay identical for a programmable number of consecutive ticks. When that count is reached, the block captures the column index and the raw row mask, and it sets a sticky interrupt. A key that stays held is reported only once. Scanning resumes after all rows read high again.

With scanning disabled, the block is in firmware mode. A column register is then writable, and its value drives the column lines directly.

Top module: `keypad_scanner`

## Requirements
- R1: After reset, `col_n` is 5'b11111, `irq` is 0, `key_col` and `key_row` are 0, and no column is driven while `scan_en` is 0.
- R2: While `scan_en` is 1, at most one bit of `col_n` is low. Table slot s is the field `order[3s+2:3s]`. The first slot holding a valid index (0 to 4) is driven first, and the following slots are visited in ascending order with wrap-around. Driving column c means `col_n` equals `~(1<<c)`.
- R3: Slots whose index is 5, 6 or 7 are passed over without using any ticks. If no slot is valid, `col_n` stays 5'b11111.
- R4: When no key is seen, each column stays driven for `rate_sel+1` ticks before the next valid slot is driven.
- R5: A tick at which any row reads low stops the sequencer on the current column. A key is accepted at the tick that ends `dbnc_sel+1` consecutive ticks of the same nonzero row pattern. Any change in the pattern restarts the count at one.
- R6: On acceptance, `key_col` takes the driven column index and `key_row` takes the row mask, where bit r is 1 when row r read low. If several rows are low, all of their bits are kept.
- R7: `irq` is set on acceptance and stays set until an `irq_clr` pulse clears it. If acceptance and `irq_clr` happen in the same cycle, `irq` stays set.
- R8: While the same pattern remains held, no further acceptance occurs. The first tick with all rows high restarts scanning, after which the same key can be reported again.
- R9: While `scan_en` is 0, `fw_col_we` loads `fw_col_wdata` into the column register, which drives `col_n`. Writes made while `scan_en` is 1 are ignored, and no key is accepted while `scan_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle scan/debounce tick enable |
| scan_en | input | 1 | Hardware scanning enable |
| rate_sel | input | 3 | Ticks per column minus one |
| dbnc_sel | input | 4 | Debounce ticks minus one |
| order | input | 15 | Five 3-bit column indices, slot 0 in bits 2:0 |
| fw_col_we | input | 1 | Column register write strobe (firmware mode) |
| fw_col_wdata | input | 5 | Column register write data |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt |
| rows_n | input | 6 | Active-low row sense inputs |
| col_n | output | 5 | Active-low column drive outputs |
| key_col | output | 3 | Captured column index |
| key_row | output | 6 | Captured row mask, bit set for each low row |
| irq | output | 1 | Sticky key interrupt |

## Verification
The assertions assume that `tick` pulses are at least two clock cycles apart. Under that assumption, a column change registered at one tick has reached `col_n` before the next tick samples the rows. They also assume that `rows_n` responds only to the column actually being driven. The bench meets both assumptions. It spaces every tick with two idle cycles, and it models the keypad as a grid of closed switches, so each row follows `col_n` combinationally. All changes to configuration inputs are made between ticks.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int KP_COLS   = 5;
  localparam int KP_ROWS   = 6;
  localparam int KP_IDX_W  = 3;
  localparam int KP_DBNC_W = 4;
  localparam int KP_RATE_W = 3;
endpackage

// File: rtl/kp_sequencer.sv
module kp_sequencer #(
  parameter int NC  = kp_pkg::KP_COLS,
  parameter int IW  = kp_pkg::KP_IDX_W,
  parameter int RW  = kp_pkg::KP_RATE_W,
  localparam int SW = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            tick,
  input  logic            hold,
  input  logic [NC*IW-1:0] order,
  input  logic [RW-1:0]   rate,
  output logic [IW-1:0]   col_idx,
  output logic            col_valid
);
  logic [IW-1:0] slot_idx [NC];
  logic [NC-1:0] slot_ok;
  logic [SW-1:0] slot, base, nxt_slot;
  logic [RW-1:0] dwell;

  for (genvar g = 0; g < NC; g++) begin : g_slot
    assign slot_idx[g] = order[g*IW +: IW];
    assign slot_ok[g]  = (int'(slot_idx[g]) < NC);
  end

  // search forward from base for the next valid slot (wraps onto itself)
  assign base = en ? slot : SW'(NC-1);
  always_comb begin
    logic found;
    found    = 1'b0;
    nxt_slot = base;
    for (int k = 1; k <= NC; k++) begin
      int c;
      c = (int'(base) + k) % NC;
      if (!found && slot_ok[c]) begin
        nxt_slot = SW'(c);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot  <= '0;
      dwell <= '0;
    end else if (!en) begin
      slot  <= nxt_slot;
      dwell <= '0;
    end else if (tick) begin
      if (hold) begin
        dwell <= '0;
      end else if (dwell == rate) begin
        dwell <= '0;
        slot  <= nxt_slot;
      end else begin
        dwell <= dwell + 1'b1;
      end
    end
  end

  assign col_idx   = slot_idx[slot];
  assign col_valid = slot_ok[slot];

  // R5
  hold_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (en && tick && hold) |=> (!en || $stable(slot)));
endmodule

// File: rtl/kp_debounce.sv
module kp_debounce #(
  parameter int NR = kp_pkg::KP_ROWS,
  parameter int DW = kp_pkg::KP_DBNC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic [NR-1:0] rows_n,
  input  logic [DW-1:0] dbnc,
  output logic [NR-1:0] pat,
  output logic          pat_any,
  output logic          accept
);
  logic [NR-1:0] last_pat;
  logic [DW:0]   cnt, new_cnt, target;
  logic          reported, same;

  assign pat     = ~rows_n;
  assign pat_any = |pat;
  assign same    = (pat == last_pat);
  assign target  = {1'b0, dbnc} + 1'b1;
  assign new_cnt = !same ? (DW+1)'(1) : ((&cnt) ? cnt : cnt + 1'b1);
  assign accept  = en && tick && pat_any && !(same && reported) && (new_cnt == target);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      last_pat <= '0;
      cnt      <= '0;
      reported <= 1'b0;
    end else if (tick) begin
      if (!pat_any) begin
        last_pat <= '0;
        cnt      <= '0;
        reported <= 1'b0;
      end else begin
        last_pat <= pat;
        cnt      <= new_cnt;
        reported <= (same && reported) || accept;
      end
    end
  end

  // R5
  accept_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && dbnc != '0) |-> (pat == last_pat));
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
  parameter int NC = kp_pkg::KP_COLS,
  parameter int NR = kp_pkg::KP_ROWS,
  parameter int IW = kp_pkg::KP_IDX_W,
  parameter int DW = kp_pkg::KP_DBNC_W,
  parameter int RW = kp_pkg::KP_RATE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            scan_en,
  input  logic [RW-1:0]   rate_sel,
  input  logic [DW-1:0]   dbnc_sel,
  input  logic [NC*IW-1:0] order,
  input  logic            fw_col_we,
  input  logic [NC-1:0]   fw_col_wdata,
  input  logic            irq_clr,
  input  logic [NR-1:0]   rows_n,
  output logic [NC-1:0]   col_n,
  output logic [IW-1:0]   key_col,
  output logic [NR-1:0]   key_row,
  output logic            irq
);
  logic [IW-1:0] col_idx;
  logic          col_valid;
  logic [NR-1:0] pat;
  logic          pat_any, acc;
  logic [NC-1:0] fw_col_q;

  kp_sequencer #(.NC(NC), .IW(IW), .RW(RW)) u_seq (
    .clk(clk), .rst(rst), .en(scan_en), .tick(tick), .hold(pat_any),
    .order(order), .rate(rate_sel), .col_idx(col_idx), .col_valid(col_valid)
  );

  kp_debounce #(.NR(NR), .DW(DW)) u_dbn (
    .clk(clk), .rst(rst), .en(scan_en), .tick(tick), .rows_n(rows_n),
    .dbnc(dbnc_sel), .pat(pat), .pat_any(pat_any), .accept(acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fw_col_q <= '1;
      col_n    <= '1;
      key_col  <= '0;
      key_row  <= '0;
      irq      <= 1'b0;
    end else begin
      if (!scan_en && fw_col_we) fw_col_q <= fw_col_wdata;
      if (!scan_en)       col_n <= fw_col_q;
      else if (col_valid) col_n <= ~({{(NC-1){1'b0}}, 1'b1} << col_idx);
      else                col_n <= '1;
      if (acc) begin
        key_col <= col_idx;
        key_row <= pat;
      end
      if (acc)          irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  // R2
  one_col_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_en && $past(scan_en)) |-> ($countones(~col_n) <= 1));
  // R6
  key_row_irq_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(key_row) |-> irq);
  // R9
  no_accept_off_chk: assert property (@(posedge clk) disable iff (rst)
    !scan_en |-> !acc);
  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !acc) |=> !irq);
endmodule

// File: tb/keypad_scanner_tb.sv
module keypad_scanner_tb;
  logic clk = 0, rst = 1, tick = 0, scan_en = 0, fw_col_we = 0, irq_clr = 0;
  logic [2:0] rate_sel = 0;
  logic [3:0] dbnc_sel = 0;
  logic [14:0] order = 0;
  logic [4:0] fw_col_wdata = 0;
  logic [5:0] rows_n;
  logic [4:0] col_n;
  logic [2:0] key_col;
  logic [5:0] key_row;
  logic irq;
  logic [5:0] pressed [5];
  int errors = 0, checks = 0, cycles = 0;

  always #5 clk = ~clk;

  keypad_scanner u_dut (.clk(clk), .rst(rst), .tick(tick), .scan_en(scan_en),
    .rate_sel(rate_sel), .dbnc_sel(dbnc_sel), .order(order), .fw_col_we(fw_col_we),
    .fw_col_wdata(fw_col_wdata), .irq_clr(irq_clr), .rows_n(rows_n), .col_n(col_n),
    .key_col(key_col), .key_row(key_row), .irq(irq));

  always_comb begin
    rows_n = '1;
    for (int c = 0; c < 5; c++)
      for (int r = 0; r < 6; r++)
        if (pressed[c][r] && !col_n[c]) rows_n[r] = 1'b0;
  end

  typedef struct packed {
    logic [14:0] ord; logic [2:0] pc; logic [5:0] pr; logic [2:0] ec; logic [5:0] er;
  } vec_t;
  localparam vec_t VEC [5] = '{
    '{ {3'd4,3'd3,3'd2,3'd1,3'd0}, 3'd2, 6'b001000, 3'd2, 6'b001000 },
    '{ {3'd0,3'd1,3'd2,3'd3,3'd4}, 3'd4, 6'b000001, 3'd4, 6'b000001 },
    '{ {3'd0,3'd5,3'd1,3'd6,3'd7}, 3'd0, 6'b100010, 3'd0, 6'b100010 },
    '{ {3'd7,3'd7,3'd7,3'd7,3'd2}, 3'd2, 6'b100000, 3'd2, 6'b100000 },
    '{ {3'd4,3'd2,3'd1,3'd0,3'd3}, 3'd3, 6'b010101, 3'd3, 6'b010101 }
  };

  function automatic logic [14:0] mk(input int a, b, c, d, e);
    return {3'(e), 3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
    @(negedge clk);
  endtask

  task automatic tick_clr();
    @(negedge clk) begin tick = 1; irq_clr = 1; end
    @(negedge clk) begin tick = 0; irq_clr = 0; end
    @(negedge clk);
  endtask

  task automatic clr();
    @(negedge clk) irq_clr = 1;
    @(negedge clk) irq_clr = 0;
  endtask

  task automatic release_all();
    for (int c = 0; c < 5; c++) pressed[c] = '0;
  endtask

  task automatic enable();
    @(negedge clk) scan_en = 1;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [4:0] drv(input int c);
    return ~(5'b1 << c);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    release_all();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 col_n", col_n, 5'h1f);
    chk("R1 irq", irq, 0);
    chk("R1 key_col", key_col, 0);
    chk("R1 key_row", key_row, 0);
    order = mk(0, 1, 2, 3, 4);
    pressed[0] = 6'b000001;
    repeat (3) do_tick();
    chk("R1 idle no drive", col_n, 5'h1f);
    chk("R1 idle no irq", irq, 0);
    release_all();

    // vector table: R2 R6 under several patterns
    for (int i = 0; i < 5; i++) begin
      @(negedge clk) scan_en = 0;
      order = VEC[i].ord;
      release_all();
      pressed[VEC[i].pc] = VEC[i].pr;
      enable();
      for (int t = 0; t < 40 && !irq; t++) do_tick();
      chk("R6 vec irq", irq, 1);
      chk("R6 vec key_col", key_col, VEC[i].ec);
      chk("R6 vec key_row", key_row, VEC[i].er);
      release_all();
      clr();
      do_tick();
      do_tick();
    end

    // R2 R4 order and dwell
    @(negedge clk) scan_en = 0;
    rate_sel = 1;
    order = mk(3, 1, 4, 0, 2);
    enable();
    chk("R2 first column", col_n, drv(3));
    for (int t = 1; t <= 10; t++) begin
      int seq [5] = '{3, 1, 4, 0, 2};
      do_tick();
      chk("R4 dwell order", col_n, drv(seq[(t / 2) % 5]));
    end

    // R3 skip slots
    @(negedge clk) scan_en = 0;
    rate_sel = 0;
    order = mk(7, 2, 5, 6, 4);
    enable();
    chk("R3 skip start", col_n, drv(2));
    do_tick();
    chk("R3 skip next", col_n, drv(4));
    do_tick();
    chk("R3 skip wrap", col_n, drv(2));
    @(negedge clk) scan_en = 0;
    order = mk(7, 6, 5, 7, 7);
    enable();
    do_tick();
    chk("R3 none valid", col_n, 5'h1f);

    // R5 debounce
    @(negedge clk) scan_en = 0;
    order = mk(1, 7, 7, 7, 7);
    dbnc_sel = 2;
    clr();
    enable();
    pressed[1] = 6'b010000;
    do_tick(); do_tick();
    chk("R5 not yet", irq, 0);
    do_tick();
    chk("R5 accepted", irq, 1);
    chk("R5 row", key_row, 6'b010000);
    clr();
    release_all();
    do_tick();
    pressed[1] = 6'b000100;
    do_tick(); do_tick();
    pressed[1] = 6'b000001;
    do_tick(); do_tick();
    chk("R5 restart count", irq, 0);
    do_tick();
    chk("R5 restart accept", irq, 1);
    chk("R5 restart row", key_row, 6'b000001);

    // R8 no repeat while held, then resume
    @(negedge clk) scan_en = 0;
    order = mk(1, 3, 7, 7, 7);
    clr();
    pressed[1] = 6'b000010;
    enable();
    for (int t = 0; t < 3; t++) do_tick();
    chk("R8 first report", irq, 1);
    clr();
    for (int t = 0; t < 5; t++) do_tick();
    chk("R8 no repeat", irq, 0);
    chk("R5 held column", col_n, drv(1));
    release_all();
    do_tick();
    chk("R8 resume scan", col_n, drv(3));
    pressed[1] = 6'b000010;
    for (int t = 0; t < 20 && !irq; t++) do_tick();
    chk("R8 report again", irq, 1);

    // R7 set wins over clear
    dbnc_sel = 0;
    order = mk(1, 7, 7, 7, 7);
    release_all();
    do_tick();
    pressed[1] = 6'b001000;
    tick_clr();
    chk("R7 set wins", irq, 1);
    chk("R7 row", key_row, 6'b001000);
    clr();
    @(negedge clk);
    chk("R7 cleared", irq, 0);

    // R9 firmware mode
    release_all();
    @(negedge clk) scan_en = 0;
    @(negedge clk) begin fw_col_we = 1; fw_col_wdata = 5'b10101; end
    @(negedge clk) fw_col_we = 0;
    @(negedge clk);
    chk("R9 fw drive", col_n, 5'b10101);
    @(negedge clk) scan_en = 1;
    @(negedge clk) begin fw_col_we = 1; fw_col_wdata = 5'b00000; end
    @(negedge clk) begin fw_col_we = 0; scan_en = 0; end
    @(negedge clk);
    @(negedge clk);
    chk("R9 write ignored", col_n, 5'b10101);
    pressed[1] = 6'b100000;
    for (int t = 0; t < 4; t++) do_tick();
    chk("R9 no accept irq", irq, 0);
    chk("R9 no accept row", key_row, 6'b001000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule